// File: doc/BRIEF.md
# Dual-Channel Sampling Converter Serial Port Controller

This block models the converter side of the serial port of a dual 12-bit sampling converter. A falling chip select starts a conversion and captures both channel samples. While chip select stays low, every falling edge of the serial clock advances a bit position. Each of the two data lanes carries a frame: two leading zeros, its own 12-bit result MSB first, then two trailing zeros. If chip select stays low long enough, the same frame layout follows for the other channel's result. The lanes go to three-state (here, the output enable drops) when chip select rises, or on the 32nd serial clock falling edge, whichever comes first.

How many serial clock falling edges pass before chip select rises also sets the power mode. A release before the 10th edge puts the block into a power-down flag state. A release between the 10th and 14th edges aborts the conversion and leaves the power state unchanged. Completing the 14th edge brings the block back to normal mode. A new conversion is accepted only after a quiet time has passed with the outputs off. An earlier chip select fall is ignored and reported with a one-cycle error pulse. Serial clock and chip select are sampled by the system clock `clk`. All edges are detected synchronously.

Top module: `adc_serial_frontend`

## Requirements
- R1: After reset the output enable, both data lanes, the power-down flag and the early-error pulse are all 0.
- R2: A chip select fall accepted while ready enables both lanes one clock later and captures both samples and the coding select. Later changes of `sample_a`, `sample_b` or `twos_mode` do not alter that frame. Positions 0 and 1 are zero.
- R3: The bit position equals the number of serial clock falling edges counted since the accepted chip select fall. Positions 2 to 13 carry the lane's own 12-bit result MSB first (position 2 is bit 11). Each position takes effect one clock after the edge is detected.
- R4: With `twos_mode`=1 the result is the sample with bit 11 inverted (two's complement of the offset-binary input). With `twos_mode`=0 the result is the sample unchanged.
- R5: Positions 14 to 17 are zero. Positions 18 to 29 carry the other channel's result MSB first (lane A carries channel B, lane B carries channel A). Positions 30 and 31 are zero.
- R6: On the 32nd serial clock falling edge the output enable drops even though chip select is still low, and further edges leave it low.
- R7: A chip select rise during a frame drops the output enable one clock later.
- R8: A chip select rise with fewer than 10 edges counted sets the power-down flag.
- R9: A chip select rise with 10 to 13 edges counted leaves the power-down flag unchanged.
- R10: Counting the 14th edge clears the power-down flag.
- R11: After the outputs turn off, a chip select fall is accepted only once QUIET_CYCLES clocks have passed. An earlier fall is ignored, keeps the output enable low, and raises `early_err` for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| twos_mode | input | 1 | 1 selects two's complement coding, 0 straight binary |
| sample_a | input | 12 | Channel A conversion result (offset binary) |
| sample_b | input | 12 | Channel B conversion result (offset binary) |
| dout_a | output | 1 | Lane A serial data |
| dout_b | output | 1 | Lane B serial data |
| dout_en | output | 1 | Output enable for both lanes; 0 means three-state |
| pwr_down | output | 1 | Power-down mode flag |
| early_err | output | 1 | One-clock pulse on a chip select fall that was too early |

## Verification
A wrong edge count appears on the lanes within one serial clock edge as a shifted bit, and on the enable at the 32nd edge or the mode flag at release. A stale quiet timer shows up as a refused or wrongly accepted conversion on the very next chip select fall. Corrupted captured codes show up at the first data position after the lane's leading zeros. Because samples and coding are scrambled right after capture, a design that reads them live fails within the first frame.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

  typedef enum logic [1:0] {SLOT_ZERO, SLOT_OWN, SLOT_OTHER} slot_kind_e;

  typedef struct packed {
    slot_kind_e  kind;
    logic [7:0]  idx;   // bit index inside the result, MSB = res-1
  } slot_t;

  // Maps a frame position to what the lane shows there.
  function automatic slot_t classify(int unsigned pos, int unsigned lead,
                                     int unsigned res, int unsigned trail);
    int unsigned half;
    int unsigned p;
    slot_t s;
    half   = lead + res + trail;
    s.kind = SLOT_ZERO;
    s.idx  = '0;
    p      = (pos >= half) ? pos - half : pos;
    if (p >= lead && p < lead + res) begin
      s.kind = (pos >= half) ? SLOT_OTHER : SLOT_OWN;
      s.idx  = 8'(res - 1 - (p - lead));
    end
    return s;
  endfunction

endpackage

// File: rtl/adcsp_edge.sv
module adcsp_edge #(
  parameter bit RST_LEVEL = 1'b1,
  parameter bit WANT_RISE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= RST_LEVEL;
    else        prev_q <= din;
  end

  generate
    if (WANT_RISE) begin : g_rise
      assign edge_o = ~prev_q & din;
    end else begin : g_fall
      assign edge_o = prev_q & ~din;
    end
  endgenerate
endmodule

// File: rtl/adcsp_seq.sv
module adcsp_seq #(
  parameter int KEEP_EDGES   = 10,
  parameter int CONV_EDGES   = 14,
  parameter int FRAME_EDGES  = 32,
  parameter int QUIET_CYCLES = 6,
  parameter int CNT_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_fall,
  output logic             start,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic             pwr_down,
  output logic             early_err
);
  localparam int QW = $clog2(QUIET_CYCLES + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [QW-1:0]    quiet_q;
  logic             pd_q;
  logic             err_q;

  // Named events for the checks below.
  logic ready, reject, count_ev, end_ev, release_ev, off_ev, conv_done_ev;
  assign ready        = !active_q && (quiet_q == '0);
  assign start        = cs_fall && ready;
  assign reject       = cs_fall && !ready;
  assign release_ev   = active_q && cs_rise;
  assign count_ev     = active_q && sclk_fall && !cs_rise;
  assign end_ev       = count_ev && (cnt_q == CNT_W'(FRAME_EDGES - 1));
  assign conv_done_ev = count_ev && (cnt_q == CNT_W'(CONV_EDGES - 1));
  assign off_ev       = end_ev || release_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      quiet_q  <= '0;
      pd_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= reject;
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (release_ev) begin
        active_q <= 1'b0;
      end else if (count_ev) begin
        cnt_q <= cnt_q + 1'b1;
        if (end_ev) active_q <= 1'b0;
      end
      if (off_ev)              quiet_q <= QW'(QUIET_CYCLES);
      else if (quiet_q != '0)  quiet_q <= quiet_q - 1'b1;
      if (release_ev && (cnt_q < CNT_W'(KEEP_EDGES))) pd_q <= 1'b1;
      else if (conv_done_ev)                         pd_q <= 1'b0;
    end
  end

  assign active    = active_q;
  assign cnt       = cnt_q;
  assign pwr_down  = pd_q;
  assign early_err = err_q;

  assert_start_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active_q && cnt_q == '0));
  assert_frame_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < CNT_W'(FRAME_EDGES)));
  assert_release_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !active_q);
  assert_pd_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ev && cnt_q < CNT_W'(KEEP_EDGES)) |=> pd_q);
  assert_pd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ev && cnt_q >= CNT_W'(KEEP_EDGES) && cnt_q < CNT_W'(CONV_EDGES))
      |=> (pd_q == $past(pd_q)));
  assert_pd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_ev |=> !pd_q);
  assert_early_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!active_q && err_q));
endmodule

// File: rtl/adcsp_lane.sv
module adcsp_lane
  import adcsp_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int LEAD_ZEROS  = 2,
  parameter int TRAIL_ZEROS = 2,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [RES_BITS-1:0] own_code,
  input  logic [RES_BITS-1:0] other_code,
  output logic                dout
);
  localparam int IW = $clog2(RES_BITS);

  slot_t slot;
  logic  bit_val;

  always_comb begin
    slot = classify(32'(cnt), LEAD_ZEROS, RES_BITS, TRAIL_ZEROS);
    case (slot.kind)
      SLOT_OWN:   bit_val = own_code[slot.idx[IW-1:0]];
      SLOT_OTHER: bit_val = other_code[slot.idx[IW-1:0]];
      default:    bit_val = 1'b0;
    endcase
  end

  assign dout = en & bit_val;

  assert_lead_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && 32'(cnt) < LEAD_ZEROS) |-> (dout == 1'b0));
endmodule

// File: rtl/adc_serial_frontend.sv
module adc_serial_frontend #(
  parameter int RES_BITS     = 12,
  parameter int LEAD_ZEROS   = 2,
  parameter int TRAIL_ZEROS  = 2,
  parameter int KEEP_EDGES   = 10,
  parameter int QUIET_CYCLES = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                twos_mode,
  input  logic [RES_BITS-1:0] sample_a,
  input  logic [RES_BITS-1:0] sample_b,
  output logic                dout_a,
  output logic                dout_b,
  output logic                dout_en,
  output logic                pwr_down,
  output logic                early_err
);
  localparam int CONV_EDGES  = LEAD_ZEROS + RES_BITS;
  localparam int FRAME_EDGES = 2 * (LEAD_ZEROS + RES_BITS + TRAIL_ZEROS);
  localparam int CNT_W       = $clog2(FRAME_EDGES + 1);

  function automatic logic [RES_BITS-1:0] encode(logic [RES_BITS-1:0] raw, logic twos);
    logic [RES_BITS-1:0] c;
    c = raw;
    c[RES_BITS-1] = raw[RES_BITS-1] ^ twos;
    return c;
  endfunction

  logic cs_fall, cs_rise, sclk_fall;

  adcsp_edge #(.RST_LEVEL(1'b1), .WANT_RISE(1'b0)) u_cs_fall (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .edge_o(cs_fall));
  adcsp_edge #(.RST_LEVEL(1'b1), .WANT_RISE(1'b1)) u_cs_rise (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .edge_o(cs_rise));
  adcsp_edge #(.RST_LEVEL(1'b1), .WANT_RISE(1'b0)) u_sclk_fall (
    .clk(clk), .rst_n(rst_n), .din(sclk), .edge_o(sclk_fall));

  logic             start, active;
  logic [CNT_W-1:0] cnt;

  adcsp_seq #(
    .KEEP_EDGES(KEEP_EDGES), .CONV_EDGES(CONV_EDGES), .FRAME_EDGES(FRAME_EDGES),
    .QUIET_CYCLES(QUIET_CYCLES), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .start(start), .active(active), .cnt(cnt),
    .pwr_down(pwr_down), .early_err(early_err));

  logic [RES_BITS-1:0] code_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q[0] <= '0;
      code_q[1] <= '0;
    end else if (start) begin
      code_q[0] <= encode(sample_a, twos_mode);
      code_q[1] <= encode(sample_b, twos_mode);
    end
  end

  logic [1:0] lane_out;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      adcsp_lane #(
        .RES_BITS(RES_BITS), .LEAD_ZEROS(LEAD_ZEROS),
        .TRAIL_ZEROS(TRAIL_ZEROS), .CNT_W(CNT_W)
      ) u_lane (
        .clk(clk), .rst_n(rst_n), .en(active), .cnt(cnt),
        .own_code(code_q[g]), .other_code(code_q[1-g]), .dout(lane_out[g]));
    end
  endgenerate

  assign dout_a  = lane_out[0];
  assign dout_b  = lane_out[1];
  assign dout_en = active;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (!dout_a && !dout_b));
endmodule

// File: tb/adc_serial_frontend_tb_top.sv
module adc_serial_frontend_tb_top;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, twos_mode = 1'b0;
  logic [11:0] sample_a = '0, sample_b = '0;
  logic dout_a, dout_b, dout_en, pwr_down, early_err;

  int  total = 0, fails = 0;
  bit  done = 1'b0;
  bit  model_pd = 1'b0;

  always #2 clk = ~clk;

  adc_serial_frontend #(.QUIET_CYCLES(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .twos_mode(twos_mode),
    .sample_a(sample_a), .sample_b(sample_b), .dout_a(dout_a), .dout_b(dout_b),
    .dout_en(dout_en), .pwr_down(pwr_down), .early_err(early_err));

  task automatic chk(bit ok, string req, int act, int exp, string what);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] code_of(logic [11:0] s, bit tw);
    return tw ? 12'((s + 12'd2048) & 12'hFFF) : s;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive_cs(logic v);
    @(negedge clk); cs_n = v; @(posedge clk); #1;
  endtask

  task automatic set_sclk(logic v);
    @(negedge clk); sclk = v; @(posedge clk); #1;
  endtask

  task automatic check_pos(int k, logic [31:0] wa, logic [31:0] wb, bit tw);
    string rq;
    if (k >= 32) begin
      chk(dout_en == 1'b0, "R6", dout_en, 0, "enable after edge 32");
      return;
    end
    rq = (k < 2) ? "R2" : (k < 14) ? (tw ? "R4" : "R3") : "R5";
    chk(dout_en == 1'b1, rq, dout_en, 1, $sformatf("enable at pos %0d", k));
    chk(dout_a == wa[31-k], rq, dout_a, wa[31-k], $sformatf("lane A pos %0d", k));
    chk(dout_b == wb[31-k], rq, dout_b, wb[31-k], $sformatf("lane B pos %0d", k));
  endtask

  task automatic run_frame(logic [11:0] sa, logic [11:0] sb, bit tw, int rel);
    logic [11:0] ca, cb;
    logic [31:0] wa, wb;
    string rq;
    ca = code_of(sa, tw);
    cb = code_of(sb, tw);
    wa = {2'b00, ca, 4'b0000, cb, 2'b00};
    wb = {2'b00, cb, 4'b0000, ca, 2'b00};
    sample_a = sa; sample_b = sb; twos_mode = tw;
    drive_cs(1'b0);
    sample_a = ~sa; sample_b = ~sb; twos_mode = ~tw;  // R2: capture must hold
    check_pos(0, wa, wb, tw);
    for (int k = 1; k <= rel; k++) begin
      set_sclk(1'b0);
      check_pos(k, wa, wb, tw);
      set_sclk(1'b1);
      if (k == 14) model_pd = 1'b0;
    end
    drive_cs(1'b1);
    if (rel < 10) model_pd = 1'b1;
    chk(dout_en == 1'b0, "R7", dout_en, 0, "enable after release");
    rq = (rel < 10) ? "R8" : (rel < 14) ? "R9" : "R10";
    chk(pwr_down == model_pd, rq, pwr_down, model_pd, $sformatf("power flag after %0d edges", rel));
    repeat (Q) tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    chk(dout_en == 0, "R1", dout_en, 0, "enable after reset");
    chk(dout_a == 0 && dout_b == 0, "R1", {dout_a, dout_b}, 0, "lanes after reset");
    chk(pwr_down == 0, "R1", pwr_down, 0, "power flag after reset");
    chk(early_err == 0, "R1", early_err, 0, "error after reset");

    // Directed: full frames, both codings, corner values
    run_frame(12'hA5C, 12'h3F1, 1'b0, 32);
    run_frame(12'h000, 12'hFFF, 1'b1, 32);
    run_frame(12'h800, 12'h7FF, 1'b1, 34);   // R6: edges beyond 32 ignored

    // Power modes: R8, R9, R10
    run_frame(12'h123, 12'h456, 1'b0, 5);
    run_frame(12'h789, 12'hABC, 1'b0, 12);   // stays down
    run_frame(12'hDEF, 12'h010, 1'b0, 14);   // cleared
    run_frame(12'h555, 12'hAAA, 1'b1, 10);   // stays normal
    run_frame(12'h321, 12'h654, 1'b0, 0);

    // R11: early fall, then exactly on time
    run_frame(12'h0F0, 12'hF0F, 1'b0, 16);
    // run_frame already waited Q cycles; make a new release window
    drive_cs(1'b0);
    drive_cs(1'b1);
    repeat (Q - 1) tick();
    drive_cs(1'b0);
    chk(early_err == 1, "R11", early_err, 1, "early fall flagged");
    chk(dout_en == 0, "R11", dout_en, 0, "early fall ignored");
    tick();
    chk(early_err == 0, "R11", early_err, 0, "error lasts one clock");
    set_sclk(1'b0);
    chk(dout_en == 0, "R11", dout_en, 0, "edge after ignored fall");
    set_sclk(1'b1);
    drive_cs(1'b1);
    repeat (Q) tick();
    drive_cs(1'b0);
    chk(early_err == 0, "R11", early_err, 0, "on-time fall not flagged");
    chk(dout_en == 1, "R11", dout_en, 1, "on-time fall accepted");
    drive_cs(1'b1);
    repeat (Q) tick();

    // Random frames
    for (int n = 0; n < 24; n++) begin
      run_frame(12'($urandom), 12'($urandom), 1'($urandom), int'($urandom_range(0, 34)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule